// File: doc/BRIEF.md
# One-Time-Clearable Byte Memory Model (Erasable PROM Emulation)

This block emulates a byte-wide erasable programmable memory in synchronous logic. A select input (`ce_n`) and a bus-drive input (`oe_n`), plus a digital flag (`vpp_hi`) that stands in for the high programming level on the shared drive/program pin, are decoded on every clock into one of several operating modes. These are read, verify (a read taken after programming), standby, output-off, program and program-inhibit. Read data leaves on `dout`, and `dout_en` tells the surrounding logic when the bus would be driven.

Programming can only clear bits. A valid program pulse ANDs the presented byte into the addressed location, so a bit that has been cleared stays cleared until the whole array is erased. A select-low pulse is accepted only if it starts as a falling edge while the program flag is already high, and only if its length falls inside a cycle window. A pulse that runs too long is reported and discarded. A synchronous erase request sweeps every location back to all ones, one location per cycle. Real access delays are replaced by a parameterised read latency in clock cycles.

Top module: `uvprom_model`

## Requirements
- R1: Read mode is `ce_n`=0, `oe_n`=0 and `vpp_hi`=0 while no erase is running. In read mode the block drives the byte stored at `addr`. Every location holds 0xFF from time zero.
- R2: `dout_en` is first seen high after the RD_LAT-th consecutive rising edge that samples read mode. It is seen low after the first edge that samples any other mode. `dout` is 0 whenever `dout_en` is 0.
- R3: Standby (`ce_n`=1, `vpp_hi`=0) keeps `dout_en` at 0 whatever `oe_n` is.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, the bus stays off and the array is not written.
- R5: A program pulse starts at the first edge that samples `ce_n`=0 with `vpp_hi`=1, provided the previous edge sampled `ce_n`=1. `addr` and `din` are captured at that edge. The pulse is judged at the first edge that samples `ce_n`=1 with `vpp_hi` still 1. If the number of low samples lies in [PULSE_MIN, PULSE_MAX], the location is written.
- R6: A write stores old AND `din`. A 1 in `din` never raises a cleared bit.
- R7: Program inhibit (`vpp_hi`=1, `ce_n`=1) keeps the bus off, ignores `oe_n` and writes nothing.
- R8: A pulse longer than PULSE_MAX writes nothing and raises `pulse_err` for exactly one cycle after the judging edge. A pulse shorter than PULSE_MIN writes nothing and raises no flag.
- R9: Select held low before `vpp_hi` rises is not a pulse. A pulse during which `vpp_hi` falls is abandoned. Neither writes.
- R10: Verify: after a valid pulse, lowering `vpp_hi` and reading the same address returns the programmed value.
- R11: `erase`=1 sampled while `busy`=0 raises `busy` from the next cycle for exactly 2^ADDR_W cycles. After that, every location reads 0xFF.
- R12: From the edge that accepts `erase` until `busy` falls, the block ignores reads, program pulses and further erase requests.
- R13: `rst` (active high) clears `busy`, `dout_en`, `pulse_err` and any pulse in progress. It leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Select, active low; also the program strobe |
| oe_n | input | 1 | Bus drive request, active low; ignored while `vpp_hi`=1 |
| vpp_hi | input | 1 | Programming level present on the shared drive pin |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte presented for programming |
| erase | input | 1 | Request a full erase to all ones |
| dout | output | DATA_W | Read data, 0 while not driven |
| dout_en | output | 1 | Bus drive enable |
| busy | output | 1 | Erase sweep in progress |
| pulse_err | output | 1 | One-cycle flag for an overlong program pulse |

## Verification
The hardest situation to reach from the ports is a pulse that is only marginally wrong. It may be one sample over the width limit, or it may begin with select already low when the program flag rises. Either case must write nothing, and the write decision is made only at the edge where select returns high. The stimulus therefore builds each pulse edge by edge with an explicit low-sample count. It includes widths at PULSE_MIN-1, PULSE_MAX and PULSE_MAX+1, a select-first sequence and a flag dropped mid-pulse. Each of these is followed by a read-back, and a behavioural reference compared on every clock catches any stray write or flag in between. A second hard case is a pulse or a repeated erase request landing inside the 4096-cycle sweep. The bench issues both during the sweep and then checks the sweep length and the all-ones result.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_READ,
      MD_OUT_OFF,
      MD_PROGRAM,
      MD_INHIBIT,
      MD_LOCKED
   } prom_mode_e;

   function automatic prom_mode_e decode_mode(input logic ce_n,
                                              input logic oe_n,
                                              input logic vpp_hi,
                                              input logic blocked);
      prom_mode_e m;
      if (blocked)      m = MD_LOCKED;
      else if (vpp_hi)  m = ce_n ? MD_INHIBIT : MD_PROGRAM;
      else if (ce_n)    m = MD_STANDBY;
      else if (oe_n)    m = MD_OUT_OFF;
      else              m = MD_READ;
      return m;
   endfunction

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
   import uvprom_pkg::*;
(
   input  logic       ce_n,
   input  logic       oe_n,
   input  logic       vpp_hi,
   input  logic       blocked,
   output prom_mode_e mode
);
   always_comb mode = decode_mode(ce_n, oe_n, vpp_hi, blocked);
endmodule

// File: rtl/uvprom_pulse_timer.sv
module uvprom_pulse_timer
   import uvprom_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 8,
   parameter int PULSE_MIN = 4,
   parameter int PULSE_MAX = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  prom_mode_e        mode,
   input  logic              ce_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              err
);
   localparam int CNT_W = $clog2(PULSE_MAX + 2);
   localparam logic [CNT_W-1:0] CMIN = CNT_W'(PULSE_MIN);
   localparam logic [CNT_W-1:0] CMAX = CNT_W'(PULSE_MAX);
   localparam logic [CNT_W-1:0] CSAT = CNT_W'(PULSE_MAX + 1);

   logic             active;
   logic             ce_q;
   logic [CNT_W-1:0] width;

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= 1'b0;
         ce_q    <= 1'b0;
         width   <= '0;
         err     <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         ce_q <= ce_n;
         err  <= 1'b0;
         if (active) begin
            unique case (mode)
               MD_PROGRAM: if (width != CSAT) width <= width + 1'b1;
               MD_INHIBIT: begin
                  err    <= (width > CMAX);
                  active <= 1'b0;
               end
               default:    active <= 1'b0;
            endcase
         end else if (mode == MD_PROGRAM && ce_q) begin
            active  <= 1'b1;
            width   <= CNT_W'(1);
            wr_addr <= addr;
            wr_data <= din;
         end
      end
   end

   always_comb
      wr_en = active && (mode == MD_INHIBIT) && (width >= CMIN) && (width <= CMAX);

endmodule

// File: rtl/uvprom_array.sv
module uvprom_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              erase,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_byte,
   output logic              busy
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [DATA_W-1:0] cells [DEPTH];
   logic [ADDR_W-1:0] sweep;

   initial begin
      for (int i = 0; i < DEPTH; i++) cells[i] = '1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         sweep <= '0;
      end else if (busy) begin
         sweep <= sweep + 1'b1;
         if (sweep == LAST) busy <= 1'b0;
      end else if (erase) begin
         busy  <= 1'b1;
         sweep <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && busy)   cells[sweep]   <= '1;
      else if (wr_en)     cells[wr_addr] <= cells[wr_addr] & wr_data;
   end

   always_comb rd_byte = cells[rd_addr];

endmodule

// File: rtl/uvprom_read_path.sv
module uvprom_read_path #(
   parameter int DATA_W = 8,
   parameter int RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_mode,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   logic [DATA_W-1:0] held;
   logic              live;

   generate
      if (RD_LAT == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst) live <= 1'b0;
            else     live <= rd_mode;
         end
      end else begin : g_counted
         localparam int LAT_W = $clog2(RD_LAT + 1);
         localparam logic [LAT_W-1:0] LTOP = LAT_W'(RD_LAT);
         logic [LAT_W-1:0] age;
         always_ff @(posedge clk) begin
            if (rst || !rd_mode) age <= '0;
            else if (age != LTOP) age <= age + 1'b1;
         end
         always_comb live = (age == LTOP);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          held <= '0;
      else if (rd_mode) held <= rd_byte;
   end

   always_comb begin
      dout_en = live;
      dout    = live ? held : '0;
   end

endmodule

// File: rtl/uvprom_model.sv
module uvprom_model
   import uvprom_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 8,
   parameter int RD_LAT    = 2,
   parameter int PULSE_MIN = 4,
   parameter int PULSE_MAX = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              erase,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              busy,
   output logic              pulse_err
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("uvprom_model: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("uvprom_model: DATA_W must be positive");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("uvprom_model: RD_LAT must be at least 1");
      end
      if (PULSE_MIN < 1 || PULSE_MAX < PULSE_MIN) begin : g_bad_pulse
         $error("uvprom_model: pulse window is empty");
      end
   endgenerate

   prom_mode_e        mode;
   logic              blocked;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_byte;

   always_comb blocked = busy | erase;

   uvprom_mode_dec u_dec (
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .vpp_hi  (vpp_hi),
      .blocked (blocked),
      .mode    (mode)
   );

   uvprom_pulse_timer #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PULSE_MIN (PULSE_MIN),
      .PULSE_MAX (PULSE_MAX)
   ) u_pulse (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode),
      .ce_n    (ce_n),
      .addr    (addr),
      .din     (din),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .err     (pulse_err)
   );

   uvprom_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_array (
      .clk     (clk),
      .rst     (rst),
      .erase   (erase),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (addr),
      .rd_byte (rd_byte),
      .busy    (busy)
   );

   uvprom_read_path #(
      .DATA_W (DATA_W),
      .RD_LAT (RD_LAT)
   ) u_read (
      .clk     (clk),
      .rst     (rst),
      .rd_mode (mode == MD_READ),
      .rd_byte (rd_byte),
      .dout    (dout),
      .dout_en (dout_en)
   );

endmodule

// File: rtl/uvprom_sva.sv
module uvprom_sva #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              ce_n,
   input logic              oe_n,
   input logic              vpp_hi,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] din,
   input logic              erase,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en,
   input logic              busy,
   input logic              pulse_err
);
   a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
      !dout_en |-> (dout == '0));

   a_r3_standby_quiet: assert property (@(posedge clk) disable iff (rst)
      ce_n |=> !dout_en);

   a_r4_drive_off: assert property (@(posedge clk) disable iff (rst)
      (!ce_n && oe_n) |=> !dout_en);

   a_r7_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
      vpp_hi |=> !dout_en);

   a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
      pulse_err |=> !pulse_err);

   a_r11_busy_start: assert property (@(posedge clk) disable iff (rst)
      (erase && !busy) |=> busy);

   a_r12_busy_silent: assert property (@(posedge clk) disable iff (rst)
      busy |-> (!dout_en && !pulse_err));

   a_r13_reset_clears: assert property (@(posedge clk)
      rst |=> (!busy && !dout_en && !pulse_err));
endmodule

bind uvprom_model uvprom_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (.*);

// File: tb/sim_uvprom_model.sv
`timescale 1ns/1ps
module sim_uvprom_model;
   localparam int AW   = 12;
   localparam int DW   = 8;
   localparam int LAT  = 2;
   localparam int PMIN = 4;
   localparam int PMAX = 20;
   localparam int DEP  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, erase = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en, busy, pulse_err;

   int n_chk = 0, n_err = 0;
   int busy_cycles = 0;
   logic last_err;

   always #2 clk = ~clk;

   uvprom_model #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT),
                  .PULSE_MIN(PMIN), .PULSE_MAX(PMAX)) u0 (
      .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
      .addr(addr), .din(din), .erase(erase), .dout(dout),
      .dout_en(dout_en), .busy(busy), .pulse_err(pulse_err));

   // behavioural reference, advanced on every rising edge
   int ref_mem [DEP];
   int m_busy, m_ep, m_rdcnt, m_rddata, m_pact, m_pcnt, m_paddr, m_pdata, m_perr, m_ceq;

   initial begin
      for (int i = 0; i < DEP; i++) ref_mem[i] = 255;
      m_busy = 0; m_ep = 0; m_rdcnt = 0; m_rddata = 0; m_pact = 0;
      m_pcnt = 0; m_paddr = 0; m_pdata = 0; m_perr = 0; m_ceq = 0;
   end

   always @(posedge clk) begin
      if (rst) begin
         m_busy = 0; m_ep = 0; m_rdcnt = 0; m_rddata = 0;
         m_pact = 0; m_pcnt = 0; m_perr = 0; m_ceq = 0;
      end else begin
         m_perr = 0;
         if (m_busy != 0) begin
            ref_mem[m_ep] = 255;
            if (m_ep == DEP - 1) m_busy = 0;
            m_ep = (m_ep + 1) % DEP;
            m_pact = 0; m_rdcnt = 0;
         end else if (erase) begin
            m_busy = 1; m_ep = 0; m_pact = 0; m_rdcnt = 0;
         end else begin
            if (!ce_n && !oe_n && !vpp_hi) begin
               m_rddata = ref_mem[addr];
               if (m_rdcnt < LAT) m_rdcnt++;
            end else m_rdcnt = 0;
            if (m_pact != 0) begin
               if (vpp_hi && !ce_n) begin
                  if (m_pcnt < PMAX + 1) m_pcnt++;
               end else begin
                  if (vpp_hi && ce_n) begin
                     if (m_pcnt > PMAX) m_perr = 1;
                     else if (m_pcnt >= PMIN) ref_mem[m_paddr] = ref_mem[m_paddr] & m_pdata;
                  end
                  m_pact = 0;
               end
            end else if (vpp_hi && !ce_n && m_ceq != 0) begin
               m_pact = 1; m_pcnt = 1; m_paddr = addr; m_pdata = din;
            end
         end
         m_ceq = ce_n;
      end
   end

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (!rst) begin
         if (busy) busy_cycles++;
         n_chk++;
         if (dout_en !== (m_rdcnt == LAT)) begin
            n_err++;
            $display("FAIL R2 dout_en act=%0b exp=%0b t=%0t", dout_en, (m_rdcnt == LAT), $time);
         end
         n_chk++;
         if (dout !== ((m_rdcnt == LAT) ? DW'(m_rddata) : '0)) begin
            n_err++;
            $display("FAIL R1 dout act=%02h exp=%02h t=%0t", dout,
                     ((m_rdcnt == LAT) ? DW'(m_rddata) : 8'h00), $time);
         end
         n_chk++;
         if (busy !== (m_busy != 0)) begin
            n_err++;
            $display("FAIL R11 busy act=%0b exp=%0b t=%0t", busy, (m_busy != 0), $time);
         end
         n_chk++;
         if (pulse_err !== (m_perr != 0)) begin
            n_err++;
            $display("FAIL R8 pulse_err act=%0b exp=%0b t=%0t", pulse_err, (m_perr != 0), $time);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_read(input int a, input int exp, input string tag);
      ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; addr = AW'(a);
      tick(LAT - 1);
      check({tag, " latency dout_en low"}, dout_en, 0);
      tick(1);
      check({tag, " dout_en"}, dout_en, 1);
      check({tag, " data"}, dout, exp);
      ce_n = 1'b1; oe_n = 1'b1;
      tick(1);
      check({tag, " release"}, dout_en, 0);
   endtask

   task automatic do_prog(input int a, input int d, input int width);
      oe_n = 1'b1; vpp_hi = 1'b1; ce_n = 1'b1;
      tick(1);
      ce_n = 1'b0; addr = AW'(a); din = DW'(d);
      tick(width);
      ce_n = 1'b1;
      tick(1);
      last_err = pulse_err;
      vpp_hi = 1'b0;
      tick(1);
   endtask

   initial begin
      tick(3);
      check("R13 reset dout_en", dout_en, 0);
      check("R13 reset busy", busy, 0);
      check("R13 reset pulse_err", pulse_err, 0);
      rst = 1'b0;
      tick(1);

      do_read(0, 8'hFF, "R1 blank loc0");
      do_read(DEP - 1, 8'hFF, "R1 blank last");

      // R3 standby ignores oe_n
      ce_n = 1'b1; oe_n = 1'b0; tick(4);
      check("R3 standby", dout_en, 0);
      oe_n = 1'b1;

      // R4 select low, drive off
      ce_n = 1'b0; oe_n = 1'b1; tick(4);
      check("R4 out off", dout_en, 0);
      ce_n = 1'b1; tick(1);

      // R5 / R10 valid pulse then verify
      do_prog(5, 8'hA5, 8);
      check("R5 no err", last_err, 0);
      do_read(5, 8'hA5, "R10 verify");
      // R6 AND behaviour
      do_prog(5, 8'h5A, PMIN);
      do_read(5, 8'h00, "R6 and to zero");
      do_prog(6, 8'hF0, PMAX);
      do_prog(6, 8'hFF, 6);
      do_read(6, 8'hF0, "R6 ones keep");

      // R7 inhibit with oe_n low
      vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b0; addr = 12'd9; din = 8'h00;
      tick(10);
      check("R7 inhibit bus", dout_en, 0);
      vpp_hi = 1'b0; oe_n = 1'b1; tick(1);
      do_read(9, 8'hFF, "R7 inhibit no write");

      // R8 too long and too short
      do_prog(10, 8'h00, PMAX + 1);
      check("R8 long flag", last_err, 1);
      check("R8 flag clears", pulse_err, 0);
      do_read(10, 8'hFF, "R8 long ignored");
      do_prog(11, 8'h00, PMIN - 1);
      check("R8 short no flag", last_err, 0);
      do_read(11, 8'hFF, "R8 short ignored");

      // R9 select low before flag rises
      ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b0; addr = 12'd12; din = 8'h00;
      tick(2);
      vpp_hi = 1'b1; tick(8);
      ce_n = 1'b1; tick(1);
      vpp_hi = 1'b0; tick(1);
      do_read(12, 8'hFF, "R9 held low ignored");
      // R9 flag dropped mid-pulse
      vpp_hi = 1'b1; ce_n = 1'b1; tick(1);
      ce_n = 1'b0; addr = 12'd13; din = 8'h00; tick(3);
      vpp_hi = 1'b0; tick(3);
      vpp_hi = 1'b1; ce_n = 1'b1; tick(1);
      vpp_hi = 1'b0; tick(1);
      do_read(13, 8'hFF, "R9 flag drop ignored");

      // R13 reset keeps contents
      do_prog(7, 8'h3C, 5);
      ce_n = 1'b0; oe_n = 1'b0; addr = 12'd7; tick(3);
      rst = 1'b1; tick(2);
      check("R13 reset mid read", dout_en, 0);
      rst = 1'b0; ce_n = 1'b1; oe_n = 1'b1; tick(1);
      do_read(7, 8'h3C, "R13 contents kept");

      // R11 / R12 erase
      do_prog(DEP - 1, 8'h12, 5);
      busy_cycles = 0;
      erase = 1'b1; tick(1);
      erase = 1'b0;
      check("R11 busy raised", busy, 1);
      ce_n = 1'b0; oe_n = 1'b0; addr = 12'd7; tick(5);
      check("R12 read ignored", dout_en, 0);
      ce_n = 1'b1; oe_n = 1'b1; tick(1);
      erase = 1'b1; tick(1); erase = 1'b0;
      do_prog(20, 8'h00, 6);
      check("R12 pulse ignored", last_err, 0);
      while (busy) tick(1);
      check("R11 busy length", busy_cycles, DEP);
      tick(2);
      check("R12 no second sweep", busy, 0);
      do_read(7, 8'hFF, "R11 erased 7");
      do_read(5, 8'hFF, "R11 erased 5");
      do_read(DEP - 1, 8'hFF, "R11 erased last");
      do_read(20, 8'hFF, "R12 prog during sweep lost");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(4 * 60000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule